// File: doc/BRIEF.md
# Square-root carry-select adder

This block adds two unsigned operands and an incoming carry with no clock and no state. The operand width is divided into groups. The lowest group ripples directly from the incoming carry. Every higher group builds two ripple chains at the same time: one assumes a carry-in of 0 and the other assumes a carry-in of 1. When the true carry reaches a group, a two-way multiplexer picks that group's sums and carry-out. The selected carry-out then steers the multiplexer of the next group. A separate setup stage forms the per-bit propagate and generate terms before the chains.

By default the groups grow by one bit each step from the bottom: 2, 3, 4, 5 and 6 bits over 20 bits. With this shape, each group's pair of chains finishes at about the time its select carry arrives. As a result, the add time grows with the square root of the width and not with the width. A second mode uses equal-size groups. In both modes the topmost group takes whatever width is left, so the groups always cover the operand exactly. The carry selected at the top of each group is also exposed on its own output.

Top module: `csel_sqrt_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^WIDTH for every input combination.
- R2: `cout_o` equals bit WIDTH of the full (WIDTH+1)-bit result of `a_i` + `b_i` + `cin_i`.
- R3: `grp_carry_o[k]` equals the carry out of the highest bit of group k, taking group 0 as the least significant. That carry is bit (top+1) of the sum of the operands masked to bits 0..top, plus `cin_i`.
- R4: `grp_carry_o[NUM_GRP-1]` always equals `cout_o`.
- R5: With GRP_MODE=0 (growing), group k is FIRST_W+k bits wide for k < NUM_GRP-1, and the top group takes the remaining bits. The defaults give groups at bits 0–1, 2–4, 5–8, 9–13 and 14–19.
- R6: With GRP_MODE=1 (equal), every group is EQ_W bits wide except the top group, which takes the remaining bits.
- R7: A carry-in of 1 with `a_i` all ones and `b_i` zero propagates through every group boundary. The result is `sum_o` = 0, `cout_o` = 1 and every bit of `grp_carry_o` set.
- R8: Zero inputs give a zero sum, zero carry-out and zero group carries. Adding zero with `cin_i`=0 returns `a_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| grp_carry_o | output | NUM_GRP | Selected carry at the top of each group |

## Verification
The bench builds three copies of the block:
- the default 20-bit growing layout (2,3,4,5,6);
- a 6-bit growing layout with groups of 1, 2 and 3 bits;
- a 6-bit equal layout with three 2-bit groups.

The two 6-bit copies are swept over every operand pair and both carry-in values. This covers every kill, propagate and generate pattern at every group boundary in both modes, including carries that cross all boundaries.

The 20-bit copy is driven with ripple patterns that end at each group boundary, with all-ones and zero operands, and with random vectors. Its group-carry vector is checked against the bit positions listed in R5.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int GRP_GROWING = 0;
  localparam int GRP_EQUAL   = 1;

  // Low bit index of group idx
  function automatic int grp_lo(input int mode, input int first_w,
                                input int eq_w, input int idx);
    if (mode == GRP_EQUAL) return idx * eq_w;
    return idx * first_w + (idx * (idx - 1)) / 2;
  endfunction

  // Width of group idx; top group absorbs the remainder
  function automatic int grp_w(input int width, input int ng, input int mode,
                               input int first_w, input int eq_w, input int idx);
    if (idx == ng - 1) return width - grp_lo(mode, first_w, eq_w, idx);
    if (mode == GRP_EQUAL) return eq_w;
    return first_w + idx;
  endfunction

endpackage

// File: rtl/csel_pg.sv
module csel_pg #(
  parameter int W = 20
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o,
  output logic [W-1:0] g_o
);
  assign p_o = a_i ^ b_i;
  assign g_o = a_i & b_i;
endmodule

// File: rtl/csel_chain.sv
module csel_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] c;

  assign c[0] = c_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign c[i+1] = g_i[i] | (p_i[i] & c[i]);
  end

  assign s_o = p_i ^ c[W-1:0];
  assign c_o = c[W];
endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W    = 4,
  parameter bit DUAL = 1'b1
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  input  logic         c_sel_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  if (DUAL) begin : g_dual
    logic [W-1:0] s0, s1;
    logic         c0, c1;

    csel_chain #(.W(W)) u_chain0 (
      .p_i(p_i), .g_i(g_i), .c_i(1'b0), .s_o(s0), .c_o(c0)
    );
    csel_chain #(.W(W)) u_chain1 (
      .p_i(p_i), .g_i(g_i), .c_i(1'b1), .s_o(s1), .c_o(c1)
    );

    assign s_o = c_sel_i ? s1 : s0;
    assign c_o = c_sel_i ? c1 : c0;
  end else begin : g_single
    csel_chain #(.W(W)) u_chain (
      .p_i(p_i), .g_i(g_i), .c_i(c_sel_i), .s_o(s_o), .c_o(c_o)
    );
  end
endmodule

// File: rtl/csel_sqrt_adder.sv
module csel_sqrt_adder
  import csel_pkg::*;
#(
  parameter int WIDTH    = 20,
  parameter int NUM_GRP  = 5,
  parameter int GRP_MODE = GRP_GROWING,
  parameter int FIRST_W  = 2,
  parameter int EQ_W     = 4
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               cin_i,
  output logic [WIDTH-1:0]   sum_o,
  output logic               cout_o,
  output logic [NUM_GRP-1:0] grp_carry_o
);
  logic [WIDTH-1:0]   p, g;
  logic [NUM_GRP-1:0] gc;
  logic [NUM_GRP-1:0] g_cin;

  csel_pg #(.W(WIDTH)) u_pg (.a_i(a_i), .b_i(b_i), .p_o(p), .g_o(g));

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    localparam int LO = grp_lo(GRP_MODE, FIRST_W, EQ_W, k);
    localparam int GW = grp_w(WIDTH, NUM_GRP, GRP_MODE, FIRST_W, EQ_W, k);

    if (k == 0) begin : g_first
      assign g_cin[k] = cin_i;
    end else begin : g_upper
      assign g_cin[k] = gc[k-1];
    end

    csel_group #(.W(GW), .DUAL(k != 0)) u_grp (
      .p_i    (p[LO +: GW]),
      .g_i    (g[LO +: GW]),
      .c_sel_i(g_cin[k]),
      .s_o    (sum_o[LO +: GW]),
      .c_o    (gc[k])
    );
  end

  assign cout_o      = gc[NUM_GRP-1];
  assign grp_carry_o = gc;
endmodule

// File: rtl/csel_sqrt_adder_chk.sv
module csel_sqrt_adder_chk
  import csel_pkg::*;
#(
  parameter int WIDTH    = 20,
  parameter int NUM_GRP  = 5,
  parameter int GRP_MODE = GRP_GROWING,
  parameter int FIRST_W  = 2,
  parameter int EQ_W     = 4
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               cin_i,
  input logic [WIDTH-1:0]   sum_o,
  input logic               cout_o,
  input logic [NUM_GRP-1:0] grp_carry_o
);
  logic [WIDTH:0] full;
  assign full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    AST_SUM_MATCH: assert (sum_o == full[WIDTH-1:0])
      else $error("sum mismatch");  // R1
    AST_COUT_MATCH: assert (cout_o == full[WIDTH])
      else $error("cout mismatch");  // R2
    AST_TOP_GRP_IS_COUT: assert (grp_carry_o[NUM_GRP-1] == cout_o)
      else $error("top group carry differs from cout");  // R4
    if (b_i == '0 && !cin_i) begin
      AST_ZERO_ADD_IDENT: assert (sum_o == a_i && grp_carry_o == '0)
        else $error("adding zero changed operand");  // R8
    end
  end

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_gchk
    localparam int TOP = grp_lo(GRP_MODE, FIRST_W, EQ_W, k)
                       + grp_w(WIDTH, NUM_GRP, GRP_MODE, FIRST_W, EQ_W, k);
    logic [WIDTH:0] msk, part;
    assign msk  = ~({(WIDTH+1){1'b1}} << TOP);
    assign part = ({1'b0, a_i} & msk) + ({1'b0, b_i} & msk) + {{WIDTH{1'b0}}, cin_i};
    always_comb begin
      AST_GRP_CARRY: assert (grp_carry_o[k] == part[TOP])
        else $error("group carry mismatch");  // R3
    end
  end
endmodule

bind csel_sqrt_adder csel_sqrt_adder_chk #(
  .WIDTH(WIDTH), .NUM_GRP(NUM_GRP), .GRP_MODE(GRP_MODE),
  .FIRST_W(FIRST_W), .EQ_W(EQ_W)
) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o), .grp_carry_o(grp_carry_o)
);

// File: tb/csel_sqrt_adder_tb.sv
module csel_sqrt_adder_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // default 20-bit growing
  logic [19:0] a, b, sum;
  logic        cin, cout;
  logic [4:0]  gcar;

  // 6-bit growing 1,2,3 and 6-bit equal 2,2,2
  logic [5:0]  sa, sb, s_g, s_e;
  logic        scin, co_g, co_e;
  logic [2:0]  gc_g, gc_e;

  csel_sqrt_adder u_dut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout), .grp_carry_o(gcar)
  );

  csel_sqrt_adder #(.WIDTH(6), .NUM_GRP(3), .GRP_MODE(0), .FIRST_W(1), .EQ_W(2)) u_dut_grow (
    .a_i(sa), .b_i(sb), .cin_i(scin), .sum_o(s_g), .cout_o(co_g), .grp_carry_o(gc_g)
  );

  csel_sqrt_adder #(.WIDTH(6), .NUM_GRP(3), .GRP_MODE(1), .FIRST_W(1), .EQ_W(2)) u_dut_eq (
    .a_i(sa), .b_i(sb), .cin_i(scin), .sum_o(s_e), .cout_o(co_e), .grp_carry_o(gc_e)
  );

  function automatic logic carry_at(input logic [31:0] x, input logic [31:0] y,
                                    input logic c, input int top);
    logic [32:0] m, t;
    m = (33'd1 << (top + 1)) - 33'd1;
    t = ({1'b0, x} & m) + ({1'b0, y} & m) + {32'd0, c};
    return t[top+1];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Top bit of each group
  int top20 [5] = '{1, 4, 8, 13, 19};
  int top_g [3] = '{0, 2, 5};
  int top_e [3] = '{1, 3, 5};

  task automatic check_big();
    logic [20:0] f;
    logic [4:0]  eg;
    f = {1'b0, a} + {1'b0, b} + {20'd0, cin};
    for (int k = 0; k < 5; k++) eg[k] = carry_at({12'd0, a}, {12'd0, b}, cin, top20[k]);
    chk("R1 sum20", {12'd0, sum}, {12'd0, f[19:0]});
    chk("R2 cout20", {31'd0, cout}, {31'd0, f[20]});
    chk("R3 R5 grp20", {27'd0, gcar}, {27'd0, eg});
    chk("R4 top20", {31'd0, gcar[4]}, {31'd0, cout});
  endtask

  task automatic check_small();
    logic [6:0] f;
    logic [2:0] eg, ee;
    f = {1'b0, sa} + {1'b0, sb} + {6'd0, scin};
    for (int k = 0; k < 3; k++) begin
      eg[k] = carry_at({26'd0, sa}, {26'd0, sb}, scin, top_g[k]);
      ee[k] = carry_at({26'd0, sa}, {26'd0, sb}, scin, top_e[k]);
    end
    chk("R1 sum_grow", {26'd0, s_g}, {26'd0, f[5:0]});
    chk("R2 cout_grow", {31'd0, co_g}, {31'd0, f[6]});
    chk("R5 grp_grow", {29'd0, gc_g}, {29'd0, eg});
    chk("R1 sum_eq", {26'd0, s_e}, {26'd0, f[5:0]});
    chk("R2 cout_eq", {31'd0, co_e}, {31'd0, f[6]});
    chk("R6 grp_eq", {29'd0, gc_e}, {29'd0, ee});
  endtask

  task automatic drive_big(input logic [19:0] x, input logic [19:0] y, input logic c);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    check_big();
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; sa = '0; sb = '0; scin = 1'b0;
    @(negedge clk);
    // R8: zero inputs
    chk("R8 zero sum", {12'd0, sum}, 32'd0);
    chk("R8 zero grp", {27'd0, gcar}, 32'd0);
    chk("R8 zero small", {23'd0, s_g, gc_e}, 32'd0);

    // R7: full propagation through every boundary
    drive_big(20'hFFFFF, 20'h0, 1'b1);
    chk("R7 allprop sum", {12'd0, sum}, 32'd0);
    chk("R7 allprop grp", {27'd0, gcar}, 32'h1F);
    drive_big(20'hFFFFF, 20'hFFFFF, 1'b1);

    // R8: add zero is identity
    drive_big(20'hA5C3E, 20'h0, 1'b0);
    chk("R8 identity", {12'd0, sum}, 32'hA5C3E);

    // R3 R5: ripple ending exactly at each boundary, and generate below it
    for (int k = 0; k < 5; k++) begin
      logic [19:0] m;
      m = 20'((21'd1 << (top20[k] + 1)) - 21'd1);
      drive_big(m, 20'h0, 1'b1);
      drive_big(m >> 1, 20'h1, 1'b0);
      drive_big(m, m, 1'b0);
    end

    // R1 R2 R3: random
    for (int i = 0; i < 3000; i++)
      drive_big(20'($urandom), 20'($urandom), 1'($urandom));

    // R1 R2 R5 R6: exhaustive on 6-bit builds
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          sa = 6'(x); sb = 6'(y); scin = 1'(c);
          @(negedge clk);
          check_small();
        end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule